// File: doc/BRIEF.md
# Converter Serial Slave Readout Port

This block is the serial read side of a 16-bit sampling converter. A host starts a conversion with a single-cycle request. The block then holds a busy flag for a fixed number of system clock cycles. This models the conversion latency. When busy drops, the word on the parallel sample input is captured as the new result. The host reads that result by pulling chip select and read enable low and toggling its own serial clock. The block is a slave to that clock.

The serial clock, chip select, read enable and serial data input are brought into the system clock domain through a synchroniser. Serial clock edges are detected in that domain. A static mode input chooses between two read styles:

- Read-after-conversion mode. The host reads once busy has fallen. The serial input is passed through behind the block's own word, so several converters can be cascaded on one data line.
- Read-during-conversion mode. The host reads the previous result while the next conversion runs. The block flags a read that a new result overtakes before all bits have been clocked out.

A result that arrives while a read is in progress waits in the result register. It is loaded into the shift path only once the current session ends.

Top module: `adc_serial_readout`

## Requirements
- R1: When `busy_o` is low, a high `conv_start_i` on a system clock edge raises `busy_o` on that edge. `busy_o` then stays high for exactly `LAT` system clock edges. A `conv_start_i` seen while `busy_o` is high is ignored: it neither lengthens the conversion nor queues a new one.
- R2: On the edge where `busy_o` falls, `sample_i` is captured as the result. A read session is active while both `cs_n_i` and `rd_n_i` are low. In a session that starts with no read in progress, `sdout_o` presents the result MSB first: bit 15 before the first serial clock rising edge, and the next bit after each falling edge. All 16 bits take 16 serial clock pulses.
- R3: While `cs_n_i` or `rd_n_i` is high, `sdout_o` is 0 and the bit count is cleared. A new session then starts again from the MSB of the latest result.
- R4: With `mode_i` = 0 (read after conversion), `sdin_i` is sampled on each serial clock rising edge. After the 16 result bits, `sdout_o` presents the sampled bits in the order they were taken. The first sampled bit appears right after the result LSB.
- R5: With `mode_i` = 1 (read during conversion), `sdin_i` is ignored, and every bit after the 16 result bits is 0.
- R6: With `mode_i` = 1, a read during a conversion returns the result of the previous conversion.
- R7: With `mode_i` = 1, suppose a conversion completes while a session is active that has seen between 1 and 15 serial clock rising edges. Then `rderr_o` is high for exactly one system clock, on the edge where `busy_o` falls. No pulse occurs if 16 or more edges were seen, if no edge was seen, or if `mode_i` = 0.
- R8: A result that completes while a read is in progress does not alter the word being shifted. It is delivered by the next session.
- R9: After reset, `busy_o`, `sdout_o` and `rderr_o` are 0, and the result register reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_start_i | input | 1 | Conversion request, sampled on the system clock |
| sample_i | input | W | Parallel sample word captured at conversion end |
| mode_i | input | 1 | 0 = read after conversion with chaining, 1 = read during conversion |
| sclk_i | input | 1 | Host serial clock (asynchronous) |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read enable, active low |
| sdin_i | input | 1 | Serial chain input from the upstream device |
| busy_o | output | 1 | High while a conversion runs |
| sdout_o | output | 1 | Serial data output |
| rderr_o | output | 1 | One-cycle pulse on an incomplete read in mode 1 |

## Verification
The assertions watch several properties on every cycle:

- The exact busy length and that busy rises only on a request.
- The quiet output whenever the port is deselected.
- The single-cycle read-error pulse, always on the busy falling edge.

Bit order, the chained bits that follow the result, and zero fill in mode 1 can only be shown by the bench's serial sessions. The same holds for reading the previous word during a conversion, and for a result that completes mid-read waiting until the next session.

// File: rtl/adc_rdo_pkg.sv
package adc_rdo_pkg;

  typedef enum logic {
    MODE_AFTER  = 1'b0,
    MODE_DURING = 1'b1
  } rdo_mode_e;

  typedef struct packed {
    logic sclk;
    logic cs_n;
    logic rd_n;
    logic sdin;
  } serial_pins_t;

  localparam serial_pins_t PINS_IDLE = '{sclk: 1'b0, cs_n: 1'b1, rd_n: 1'b1, sdin: 1'b0};

endpackage

// File: rtl/adc_rdo_sync.sv
module adc_rdo_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {STAGES{RST_VAL}};
    end else begin
      stage_q <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/adc_rdo_conv_timer.sv
module adc_rdo_conv_timer #(
  parameter int W   = 16,
  parameter int LAT = 160
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] sample_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);

  localparam int CW = $clog2(LAT + 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic [W-1:0]  result_q;
  logic          result_en;
  logic          last_cycle;

  // Next-state logic
  always_comb begin
    busy_d     = busy_q;
    cnt_d      = cnt_q;
    cnt_en     = 1'b0;
    last_cycle = busy_q && (cnt_q == '0);
    result_en  = last_cycle;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        cnt_d  = CW'(LAT - 1);
        cnt_en = 1'b1;
      end
    end else if (last_cycle) begin
      busy_d = 1'b0;
    end else begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      result_q <= '0;
    end else begin
      busy_q <= busy_d;
      if (cnt_en)    cnt_q    <= cnt_d;
      if (result_en) result_q <= sample_i;
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = last_cycle;
  assign result_o = result_q;

endmodule

// File: rtl/adc_rdo_shifter.sv
module adc_rdo_shifter
  import adc_rdo_pkg::*;
#(
  parameter int W    = 16,
  parameter int CNTW = $clog2(W) + 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         sdin_i,
  input  rdo_mode_e    mode_i,
  input  logic [W-1:0] word_i,
  input  logic         conv_done_i,
  output logic         sdout_o,
  output logic         rderr_o
);

  logic [CNTW-1:0] rcnt_q, rcnt_d;
  logic            rcnt_en;
  logic            cap_q;
  logic            cap_en;
  logic [W-1:0]    sreg_q, sreg_d;
  logic            sreg_en;
  logic            rderr_q, rderr_d;
  logic            in_prog;
  logic            word_done;
  logic            chain_bit;

  always_comb begin
    in_prog   = active_i && (rcnt_q != '0);
    word_done = rcnt_q >= CNTW'(W);
    chain_bit = (mode_i == MODE_AFTER) ? cap_q : 1'b0;

    // Bit counter: cleared outside a session, saturates at all ones
    rcnt_d  = rcnt_q;
    rcnt_en = 1'b0;
    if (!active_i) begin
      rcnt_d  = '0;
      rcnt_en = 1'b1;
    end else if (rise_i && (rcnt_q != {CNTW{1'b1}})) begin
      rcnt_d  = rcnt_q + 1'b1;
      rcnt_en = 1'b1;
    end

    // Chain input is taken on the rising edge, opposite to the shift edge
    cap_en = active_i && rise_i;

    // Shift path: reload the latest result unless a read is under way
    sreg_d  = sreg_q;
    sreg_en = 1'b0;
    if (!in_prog) begin
      sreg_d  = word_i;
      sreg_en = 1'b1;
    end else if (fall_i) begin
      sreg_d  = {sreg_q[W-2:0], chain_bit};
      sreg_en = 1'b1;
    end

    rderr_d = conv_done_i && (mode_i == MODE_DURING) && in_prog && !word_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q  <= '0;
      cap_q   <= 1'b0;
      sreg_q  <= '0;
      rderr_q <= 1'b0;
    end else begin
      if (rcnt_en) rcnt_q <= rcnt_d;
      if (cap_en)  cap_q  <= sdin_i;
      if (sreg_en) sreg_q <= sreg_d;
      rderr_q <= rderr_d;
    end
  end

  assign sdout_o = active_i & sreg_q[W-1];
  assign rderr_o = rderr_q;

endmodule

// File: rtl/adc_serial_readout.sv
module adc_serial_readout
  import adc_rdo_pkg::*;
#(
  parameter int W    = 16,
  parameter int LAT  = 160,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conv_start_i,
  input  logic [W-1:0] sample_i,
  input  logic         mode_i,
  input  logic         sclk_i,
  input  logic         cs_n_i,
  input  logic         rd_n_i,
  input  logic         sdin_i,
  output logic         busy_o,
  output logic         sdout_o,
  output logic         rderr_o
);

  localparam int CNTW = $clog2(W) + 2;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // Serial pins into the system clock domain
  serial_pins_t pins_raw, pins_s;
  assign pins_raw = '{sclk: sclk_i, cs_n: cs_n_i, rd_n: rd_n_i, sdin: sdin_i};

  adc_rdo_sync #(
    .WIDTH  (4),
    .STAGES (SYNC),
    .RST_VAL(PINS_IDLE)
  ) pin_sync_i (
    .clk  (clk),
    .rst_n(rst_n_int),
    .d_i  (pins_raw),
    .q_o  (pins_s)
  );

  logic sclk_prev_q;
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) sclk_prev_q <= 1'b0;
    else            sclk_prev_q <= pins_s.sclk;
  end

  logic active, sclk_rise, sclk_fall;
  assign active    = ~pins_s.cs_n & ~pins_s.rd_n;
  assign sclk_rise = active &  pins_s.sclk & ~sclk_prev_q;
  assign sclk_fall = active & ~pins_s.sclk &  sclk_prev_q;

  // Conversion model
  logic         conv_done;
  logic [W-1:0] result;

  adc_rdo_conv_timer #(
    .W  (W),
    .LAT(LAT)
  ) conv_i (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .start_i (conv_start_i),
    .sample_i(sample_i),
    .busy_o  (busy_o),
    .done_o  (conv_done),
    .result_o(result)
  );

  // Serial output path
  adc_rdo_shifter #(
    .W   (W),
    .CNTW(CNTW)
  ) shift_i (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .active_i   (active),
    .rise_i     (sclk_rise),
    .fall_i     (sclk_fall),
    .sdin_i     (pins_s.sdin),
    .mode_i     (rdo_mode_e'(mode_i)),
    .word_i     (result),
    .conv_done_i(conv_done),
    .sdout_o    (sdout_o),
    .rderr_o    (rderr_o)
  );

endmodule

// File: rtl/adc_serial_readout_chk.sv
module adc_serial_readout_chk #(
  parameter int LAT = 160
) (
  input logic clk,
  input logic rst_n,
  input logic conv_start_i,
  input logic cs_n_i,
  input logic rd_n_i,
  input logic busy_o,
  input logic sdout_o,
  input logic rderr_o
);

  localparam int BW = $clog2(LAT + 2);

  logic [BW-1:0] busy_len_q;
  logic [2:0]    idle_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_len_q <= '0;
      idle_len_q <= '0;
    end else begin
      busy_len_q <= busy_o ? busy_len_q + 1'b1 : '0;
      if (cs_n_i || rd_n_i) begin
        if (idle_len_q != 3'd7) idle_len_q <= idle_len_q + 1'b1;
      end else begin
        idle_len_q <= '0;
      end
    end
  end

  // R1: busy spans exactly LAT edges
  assert_busy_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_len_q == BW'(LAT)));

  // R1: a request cannot extend busy past LAT edges
  assert_busy_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (busy_len_q < BW'(LAT)));

  // R1: busy rises only after a request
  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(conv_start_i));

  // R3: deselected port keeps the data line low
  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_len_q >= 3'd3) |-> !sdout_o);

  // R7: error pulse lasts one cycle
  assert_rderr_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rderr_o |=> !rderr_o);

  // R7: error pulse coincides with the end of a conversion
  assert_rderr_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rderr_o |-> $fell(busy_o));

endmodule

bind adc_serial_readout adc_serial_readout_chk #(.LAT(LAT)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .conv_start_i(conv_start_i),
  .cs_n_i      (cs_n_i),
  .rd_n_i      (rd_n_i),
  .busy_o      (busy_o),
  .sdout_o     (sdout_o),
  .rderr_o     (rderr_o)
);

// File: tb/adc_serial_readout_tb_top.sv
module adc_serial_readout_tb_top;

  localparam int W   = 16;
  localparam int LAT = 160;

  logic         clk;
  logic         rst_n;
  logic         conv_start_i;
  logic [W-1:0] sample_i;
  logic         mode_i;
  logic         sclk_i, cs_n_i, rd_n_i, sdin_i;
  logic         busy_o, sdout_o, rderr_o;

  int n_chk = 0;
  int n_bad = 0;
  int rderr_cycles = 0;
  bit done = 0;

  adc_serial_readout #(.W(W), .LAT(LAT), .SYNC(2)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_start_i(conv_start_i),
    .sample_i    (sample_i),
    .mode_i      (mode_i),
    .sclk_i      (sclk_i),
    .cs_n_i      (cs_n_i),
    .rd_n_i      (rd_n_i),
    .sdin_i      (sdin_i),
    .busy_o      (busy_o),
    .sdout_o     (sdout_o),
    .rderr_o     (rderr_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) if (rst_n === 1'b1 && rderr_o === 1'b1) rderr_cycles++;

  function automatic logic [31:0] exp_stream(logic m, logic [15:0] word, logic [31:0] chain);
    return {word, (m ? 16'h0000 : chain[31:16])};
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_conv(logic [15:0] s);
    sample_i     = s;
    conv_start_i = 1'b1;
    cyc(1);
    conv_start_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) cyc(1);
    cyc(2);
  endtask

  task automatic open_read();
    cs_n_i = 1'b0;
    rd_n_i = 1'b0;
    cyc(6);
  endtask

  task automatic close_read();
    cs_n_i = 1'b1;
    rd_n_i = 1'b1;
    sdin_i = 1'b0;
    cyc(6);
  endtask

  task automatic clock_bits(int n, int hp, logic [31:0] chain, int offs,
                            inout logic [31:0] got);
    for (int i = 0; i < n; i++) begin
      sdin_i = chain[31 - offs - i];
      cyc(1);
      sclk_i = 1'b1;
      cyc(hp);
      got    = {got[30:0], sdout_o};
      sclk_i = 1'b0;
      cyc(hp);
    end
  endtask

  task automatic full_read(int n, int hp, logic [31:0] chain, output logic [31:0] got);
    got = '0;
    open_read();
    clock_bits(n, hp, chain, 0, got);
    close_read();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    logic [31:0] chain;
    logic [15:0] prev, cur;
    int          cnt;
    int          err0;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; conv_start_i = 1'b0; sample_i = '0; mode_i = 1'b0;
    sclk_i = 1'b0; cs_n_i = 1'b1; rd_n_i = 1'b1; sdin_i = 1'b0;
    cyc(4);
    rst_n = 1'b1;
    cyc(4);

    // R9 reset state
    chk("R9 busy", busy_o, 0);
    chk("R9 sdout", sdout_o, 0);
    chk("R9 rderr", rderr_o, 0);
    full_read(16, 3, 32'hFFFF_FFFF, got);
    chk("R9 result zero", got[15:0], 16'h0000);

    // R1 busy length, request during busy ignored
    start_conv(16'hA5C3);
    cnt = 0;
    while (busy_o) begin
      cnt++;
      conv_start_i = (cnt == 50);
      cyc(1);
    end
    conv_start_i = 1'b0;
    chk("R1 busy length", cnt, LAT);
    cyc(3);
    chk("R1 no queued start", busy_o, 0);

    // R2 + R4 read after conversion with chain
    mode_i = 1'b0;
    chain  = 32'h3C96_0000;
    full_read(32, 3, chain, got);
    chk("R2 result msb first", got[31:16], 16'hA5C3);
    chk("R4 chain follows", got[15:0], 16'h3C96);

    // R3 restart from MSB, idle level
    open_read();
    got = '0;
    clock_bits(5, 3, 32'h0, 0, got);
    close_read();
    chk("R3 idle level", sdout_o, 0);
    cs_n_i = 1'b0; cyc(6);
    chk("R3 rd high idle", sdout_o, 0);
    cs_n_i = 1'b1; cyc(6);
    full_read(16, 3, 32'h0, got);
    chk("R3 restart MSB", got[15:0], 16'hA5C3);

    // R5 mode 1 ignores chain input
    mode_i = 1'b1;
    full_read(32, 3, 32'hFFFF_FFFF, got);
    chk("R5 zero fill", got, exp_stream(1'b1, 16'hA5C3, 32'hFFFF_FFFF));

    // R6 + R7 fast read during conversion: previous word, no error
    err0 = rderr_cycles;
    start_conv(16'h1234);
    got = '0;
    open_read();
    clock_bits(16, 3, 32'h0, 0, got);
    close_read();
    chk("R6 previous word", got[15:0], 16'hA5C3);
    wait_idle();
    chk("R7 complete read no error", rderr_cycles - err0, 0);

    // R7 slow read overtaken: one-cycle pulse
    err0 = rderr_cycles;
    start_conv(16'h5678);
    got = '0;
    open_read();
    clock_bits(16, 8, 32'h0, 0, got);
    close_read();
    wait_idle();
    chk("R7 incomplete read pulse", rderr_cycles - err0, 1);
    chk("R6 slow read previous", got[15:0], 16'h1234);

    // R7 mode 0 never flags
    mode_i = 1'b0;
    err0 = rderr_cycles;
    start_conv(16'h9ABC);
    got = '0;
    open_read();
    clock_bits(16, 8, 32'h0, 0, got);
    close_read();
    wait_idle();
    chk("R7 mode0 no error", rderr_cycles - err0, 0);

    // R8 result arrives mid-read
    chain = 32'hC0DE_0000;
    got = '0;
    open_read();
    clock_bits(8, 4, chain, 0, got);
    start_conv(16'h0F0F);
    clock_bits(24, 8, chain, 8, got);
    chk("R8 busy done during read", busy_o, 0);
    close_read();
    chk("R8 word intact", got, exp_stream(1'b0, 16'h9ABC, chain));
    full_read(16, 3, 32'h0, got);
    chk("R8 new word next session", got[15:0], 16'h0F0F);

    // Random sessions
    err0 = rderr_cycles;
    prev = 16'h0F0F;
    for (int k = 0; k < 40; k++) begin
      logic m;
      int   hp;
      m     = 1'($urandom);
      cur   = 16'($urandom);
      chain = $urandom;
      hp    = 2 + int'($urandom % 4);
      mode_i = m;
      start_conv(cur);
      wait_idle();
      full_read(32, hp, chain, got);
      if (m) chk("R5 random", got, exp_stream(m, cur, chain));
      else   chk("R4 random", got, exp_stream(m, cur, chain));
      prev = cur;
    end
    chk("R7 random no error", rderr_cycles - err0, 0);
    chk("R2 last word", prev, cur);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule